// File: doc/BRIEF.md
# GPIO bank interrupt detector

This block watches the input lines of one GPIO bank, up to 28 pins, and raises one interrupt line for the whole bank. Each pin has a 4-bit trigger mode. Its bits select falling-edge, rising-edge, low-level and high-level detection, and any combination is allowed. Rising and falling together give detection on both edges.

Edge events are held in a per-pin latch until software clears them. Level causes are not held: they follow the synchronized input. A per-pin enable gates each cause into a bank status word, and the OR of that word drives the interrupt line.

Software uses a 32-bit register bus that reads in the same cycle. Trigger modes and enables change only through two address aliases, one for atomic set and one for atomic clear. A write to the plain address has no effect.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every trigger mode is 0, every enable is 0, every edge latch is clear, `irq_o` is low, and the control, enable and status registers all read 0.
- R2: A write to the set alias of a pin's control word (byte offset 0x004 + 8*pin, plus 0x2000) ORs the 1 bits of `wdata_i[23:20]` into that pin's mode. A write to the clear alias (plus 0x3000) removes the written 1 bits. All other mode bits are unchanged.
- R3: Writes to a plain address (address bits 13:12 = 00) change no mode and no enable. A write to the status register, at any alias, changes nothing.
- R4: A control word read returns the mode in bits 23:20 and 0 in every other bit, bit 28 included.
- R5: The enable register at offset 0x11C holds one bit per pin, bit n for pin n. It is set through offset +0x2000 and cleared through +0x3000. Bits at or above the pin count read 0.
- R6: With mode bit 1 set, a rising input edge sets the pin's latch. The latch stays set after the input falls back.
- R7: With mode bit 0 set, a falling edge sets the latch. With only bit 0 set, a rising edge does not. With bits 0 and 1 set, both edges latch.
- R8: Mode bit 3 flags a synchronized high input and mode bit 2 a synchronized low input. These level causes are not latched and clear two edges after the input leaves the level.
- R9: Status bit n, at offset 0x124, equals (latch OR level match) AND enable of pin n. Clearing an enable hides the latch but keeps it. Setting the enable again shows the latch again.
- R10: Writing 1 to bit 28 through a pin's control set alias clears only that pin's latch and leaves its mode unchanged. An edge detected in the same cycle as this clear wins, and the latch stays set.
- R11: `irq_o` is high exactly when some status bit is set.
- R12: Inputs pass through two flops. A level change shows in status after the second clock edge. An edge latch shows after the third clock edge, counted from the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | ADDR_W | Byte address; bits 13:12 select plain, set or clear alias |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, same cycle |
| irq_o | output | 1 | Bank interrupt, OR of status bits |

## Verification
The bench targets the cycle where an edge and a latch clear meet. A design that lets the clear win would lose an event in that cycle. It also checks that level modes drop once the input returns, which a design that latched levels would fail. The bench disables a pin with a latched event and enables it again: the event must reappear. A design that cleared the latch on disable would hide that event for good. Plain-address and status-register writes are checked to have no effect, which catches a decode that ignores the alias bits. Random mode, enable, clear and pin changes are compared against a bench model of status and `irq_o`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    ALIAS_PLAIN = 2'b00,
    ALIAS_XOR   = 2'b01,
    ALIAS_SET   = 2'b10,
    ALIAS_CLR   = 2'b11
  } alias_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CTRL,
    RD_EN,
    RD_STAT
  } rd_sel_e;

  localparam int          MODE_LSB    = 20;
  localparam int          MODE_W      = 4;
  localparam int          ACK_BIT     = 28;
  localparam int          CTRL_BASE   = 'h004;
  localparam int          CTRL_STRIDE = 8;
  localparam logic [11:0] EN_OFS      = 12'h11C;
  localparam logic [11:0] STAT_OFS    = 12'h124;

  // mode bit positions
  localparam int MB_FALL = 0;
  localparam int MB_RISE = 1;
  localparam int MB_LOW  = 2;
  localparam int MB_HIGH = 3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NP     = 28,
  parameter int AW     = 14,
  parameter int PIN_IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [31:0]          wdata_i,
  output logic [NP-1:0][3:0]   mode_set_o,
  output logic [NP-1:0][3:0]   mode_clr_o,
  output logic [NP-1:0]        ack_o,
  output logic [NP-1:0]        en_set_o,
  output logic [NP-1:0]        en_clr_o,
  output rd_sel_e              rd_sel_o,
  output logic [PIN_IW-1:0]    rd_pin_o
);
  logic [11:0] ofs;
  alias_e      ali;
  logic        wr;
  logic        unused_bits;

  assign ofs = addr_i[11:0];
  assign ali = alias_e'(addr_i[13:12]);
  assign wr  = req_i & we_i;
  assign unused_bits = ^addr_i ^ ^wdata_i;

  always_comb begin
    mode_set_o = '0;
    mode_clr_o = '0;
    ack_o      = '0;
    en_set_o   = '0;
    en_clr_o   = '0;
    rd_sel_o   = RD_NONE;
    rd_pin_o   = '0;
    for (int p = 0; p < NP; p++) begin
      if (ofs == 12'(CTRL_BASE + p * CTRL_STRIDE)) begin
        rd_sel_o = RD_CTRL;
        rd_pin_o = PIN_IW'(p);
        if (wr && ali == ALIAS_SET) begin
          mode_set_o[p] = wdata_i[MODE_LSB +: MODE_W];
          ack_o[p]      = wdata_i[ACK_BIT];
        end
        if (wr && ali == ALIAS_CLR) mode_clr_o[p] = wdata_i[MODE_LSB +: MODE_W];
      end
    end
    if (ofs == EN_OFS) begin
      rd_sel_o = RD_EN;
      if (wr && ali == ALIAS_SET) en_set_o = wdata_i[NP-1:0];
      if (wr && ali == ALIAS_CLR) en_clr_o = wdata_i[NP-1:0];
    end
    if (ofs == STAT_OFS) rd_sel_o = RD_STAT;
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_set_i,
  input  logic [3:0] mode_clr_i,
  input  logic       en_set_i,
  input  logic       en_clr_i,
  input  logic       ack_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic [3:0] mode_o,
  output logic       en_o,
  output logic       latch_o,
  output logic       status_o
);
  logic [3:0] mode_q;
  logic       en_q, latch_q;
  logic       edge_hit, lvl_hit;

  assign edge_hit = (rise_i & mode_q[MB_RISE]) | (fall_i & mode_q[MB_FALL]);
  assign lvl_hit  = (lvl_i & mode_q[MB_HIGH]) | (~lvl_i & mode_q[MB_LOW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      en_q    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      mode_q  <= (mode_q | mode_set_i) & ~mode_clr_i;
      en_q    <= (en_q | en_set_i) & ~en_clr_i;
      // a fresh edge beats a simultaneous clear
      latch_q <= edge_hit | (latch_q & ~ack_i);
    end
  end

  assign mode_o   = mode_q;
  assign en_o     = en_q;
  assign latch_o  = latch_q;
  assign status_o = (latch_q | lvl_hit) & en_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 28,
  parameter int ADDR_W   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                irq_o
);
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0]      lvl, rise, fall;
  logic [NUM_PINS-1:0][3:0] mode_set, mode_clr, mode_q;
  logic [NUM_PINS-1:0]      ack, en_set, en_clr, en_q, latch_q, status;
  rd_sel_e                  rd_sel;
  logic [PIN_IW-1:0]        rd_pin;

  gpio_irq_sync #(.W(NUM_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (pins_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  gpio_irq_decode #(.NP(NUM_PINS), .AW(ADDR_W), .PIN_IW(PIN_IW)) i_decode (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mode_set_o (mode_set),
    .mode_clr_o (mode_clr),
    .ack_o      (ack),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .rd_sel_o   (rd_sel),
    .rd_pin_o   (rd_pin)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_irq_pin i_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_set_i (mode_set[p]),
      .mode_clr_i (mode_clr[p]),
      .en_set_i   (en_set[p]),
      .en_clr_i   (en_clr[p]),
      .ack_i      (ack[p]),
      .lvl_i      (lvl[p]),
      .rise_i     (rise[p]),
      .fall_i     (fall[p]),
      .mode_o     (mode_q[p]),
      .en_o       (en_q[p]),
      .latch_o    (latch_q[p]),
      .status_o   (status[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (rd_sel)
      RD_CTRL: rdata_o[MODE_LSB +: MODE_W] = mode_q[rd_pin];
      RD_EN:   rdata_o[NUM_PINS-1:0] = en_q;
      RD_STAT: rdata_o[NUM_PINS-1:0] = status;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |status;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NP = 28,
  parameter int AW = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [31:0]        wdata_i,
  input logic               irq_o,
  input logic [NP-1:0][3:0] mode_q,
  input logic [NP-1:0]      en_q,
  input logic [NP-1:0]      latch_q
);
  logic plain_wr, alias_wr, ack_wr;
  assign plain_wr = req_i && we_i && !addr_i[13];
  assign alias_wr = req_i && we_i && addr_i[13];
  assign ack_wr   = req_i && we_i && (addr_i[13:12] == 2'b10) && wdata_i[28];

  assert_reset_clean_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (en_q == '0 && latch_q == '0 && mode_q == '0 && !irq_o));

  assert_plain_wr_inert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_wr |=> ($stable(mode_q) && $stable(en_q)));

  assert_en_alias_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alias_wr |=> $stable(en_q));

  assert_latch_clear_needs_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_wr |=> ((~latch_q & $past(latch_q)) == '0));

  assert_irq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NP(NUM_PINS), .AW(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .mode_q  (mode_q),
  .en_q    (en_q),
  .latch_q (latch_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int NP = 28;
  localparam int AW = 14;
  localparam logic [31:0] PMASK = 32'h0FFF_FFFF;
  localparam logic [AW-1:0] A_SET = 14'h2000;
  localparam logic [AW-1:0] A_CLR = 14'h3000;
  localparam logic [AW-1:0] A_EN  = 14'h011C;
  localparam logic [AW-1:0] A_ST  = 14'h0124;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP-1:0] pins_i = '0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [3:0]    mdl_mode [NP];
  logic [NP-1:0] mdl_en, mdl_latch, cur;

  always #2 clk_i = ~clk_i;

  gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_irq_bank (.*);

  function automatic logic [AW-1:0] ctrl(input int p);
    return AW'(4 + 8 * p);
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    for (int p = 0; p < NP; p++)
      s[p] = (mdl_latch[p] | (cur[p] & mdl_mode[p][3]) | (~cur[p] & mdl_mode[p][2])) & mdl_en[p];
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic setpin(input int p, input logic v);
    @(negedge clk_i);
    pins_i[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
  endtask

  task automatic stbit(input string tag, input int p, input logic exp);
    logic [31:0] d;
    rd(A_ST, d);
    chk(tag, {31'b0, d[p]}, {31'b0, exp});
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;

    // R1 reset state
    rd(A_ST, d);     chk("R1 status", d, 0);
    rd(A_EN, d);     chk("R1 enable", d, 0);
    rd(ctrl(5), d);  chk("R1 ctrl", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R2 / R4 alias writes and read format
    wr(A_SET | ctrl(3), 32'h00A0_0000);
    rd(ctrl(3), d); chk("R2 set mode", d, 32'h00A0_0000);
    wr(A_CLR | ctrl(3), 32'h0020_0000);
    rd(ctrl(3), d); chk("R2 clr mode", d, 32'h0080_0000);
    wr(A_SET | ctrl(3), 32'hEFFF_FFFF);
    rd(ctrl(3), d); chk("R4 only mode bits read", d, 32'h00F0_0000);
    wr(A_CLR | ctrl(3), 32'h00F0_0000);
    rd(ctrl(3), d); chk("R2 clr all", d, 0);

    // R3 plain and status writes inert
    wr(ctrl(3), 32'h00F0_0000);
    rd(ctrl(3), d); chk("R3 plain ctrl write", d, 0);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R3 plain en write", d, 0);
    wr(A_SET | A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R3 status write", d, 0);

    // R5 enable register
    wr(A_SET | A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R5 set all", d, PMASK);
    wr(A_CLR | A_EN, 32'hFFFF_FFDF);
    rd(A_EN, d); chk("R5 clear keeps bit5", d, 32'h20);
    wr(A_CLR | A_EN, 32'h20);
    rd(A_EN, d); chk("R5 clear", d, 0);

    // R6 / R12 rising edge latency and latching on pin 2
    wr(A_SET | ctrl(2), 32'h0020_0000);
    wr(A_SET | A_EN, 32'h4);
    setpin(2, 1);
    stbit("R12 not after 1 edge", 2, 0);
    stbit("R12 not after 2 edges", 2, 0);
    stbit("R6 latched after 3 edges", 2, 1);
    setpin(2, 0); settle();
    stbit("R6 held after fall", 2, 1);
    chk("R11 irq high", {31'b0, irq_o}, 1);
    // R10 ack
    wr(A_SET | ctrl(2), 32'h1000_0000);
    stbit("R10 ack clears", 2, 0);
    rd(ctrl(2), d); chk("R10 mode kept", d, 32'h0020_0000);
    chk("R11 irq low", {31'b0, irq_o}, 0);

    // R9 disable keeps latch
    setpin(2, 1); settle();
    wr(A_CLR | A_EN, 32'h4);
    stbit("R9 hidden when disabled", 2, 0);
    chk("R9 irq low when disabled", {31'b0, irq_o}, 0);
    wr(A_SET | A_EN, 32'h4);
    stbit("R9 latch reappears", 2, 1);
    setpin(2, 0); settle();
    wr(A_SET | ctrl(2), 32'h1000_0000);
    stbit("R10 cleared before race", 2, 0);

    // R10 edge beats clear in same cycle
    setpin(2, 1);
    @(posedge clk_i); @(posedge clk_i);
    wr(A_SET | ctrl(2), 32'h1000_0000);
    stbit("R10 edge wins over clear", 2, 1);
    wr(A_SET | ctrl(2), 32'h1000_0000);
    stbit("R10 later clear", 2, 0);

    // R7 both edges on pin 6, falling-only on pin 7
    wr(A_SET | ctrl(6), 32'h0030_0000);
    wr(A_SET | ctrl(7), 32'h0010_0000);
    wr(A_SET | A_EN, 32'hC0);
    setpin(6, 1); settle();
    stbit("R7 both: rise", 6, 1);
    wr(A_SET | ctrl(6), 32'h1000_0000);
    setpin(6, 0); settle();
    stbit("R7 both: fall", 6, 1);
    setpin(7, 1); settle();
    stbit("R7 fall-only ignores rise", 7, 0);
    setpin(7, 0); settle();
    stbit("R7 fall-only latches fall", 7, 1);

    // R8 levels
    wr(A_SET | ctrl(9), 32'h0080_0000);
    wr(A_SET | A_EN, 32'h200);
    setpin(9, 1);
    stbit("R12 level not after 1 edge", 9, 0);
    stbit("R8 high level after 2 edges", 9, 1);
    setpin(9, 0);
    stbit("R8 high held 1 edge", 9, 1);
    stbit("R8 high level drops", 9, 0);
    wr(A_SET | ctrl(10), 32'h0040_0000);
    wr(A_SET | A_EN, 32'h400);
    stbit("R8 low level", 10, 1);
    setpin(10, 1); settle();
    stbit("R8 low level drops", 10, 0);

    // cleanup for random phase
    pins_i = '0; settle();
    for (int p = 0; p < NP; p++) begin
      wr(A_CLR | ctrl(p), 32'h00F0_0000);
      wr(A_SET | ctrl(p), 32'h1000_0000);
    end
    wr(A_CLR | A_EN, 32'hFFFF_FFFF);
    for (int p = 0; p < NP; p++) mdl_mode[p] = '0;
    mdl_en = '0; mdl_latch = '0; cur = '0;

    for (int it = 0; it < 150; it++) begin
      int op, p;
      logic [3:0] nib;
      logic [31:0] m;
      logic [NP-1:0] nx;
      op  = $urandom_range(0, 5);
      p   = $urandom_range(0, NP - 1);
      nib = 4'($urandom);
      m   = $urandom & PMASK;
      case (op)
        0: begin
          wr(A_SET | ctrl(p), {8'b0, nib, 20'b0});
          mdl_mode[p] = mdl_mode[p] | nib;
          rd(ctrl(p), d); chk("R2 random set", d, {8'b0, mdl_mode[p], 20'b0});
        end
        1: begin
          wr(A_CLR | ctrl(p), {8'b0, nib, 20'b0});
          mdl_mode[p] = mdl_mode[p] & ~nib;
          rd(ctrl(p), d); chk("R2 random clr", d, {8'b0, mdl_mode[p], 20'b0});
        end
        2: begin wr(A_SET | A_EN, m); mdl_en = mdl_en | m[NP-1:0]; end
        3: begin wr(A_CLR | A_EN, m); mdl_en = mdl_en & ~m[NP-1:0]; end
        4: begin wr(A_SET | ctrl(p), 32'h1000_0000); mdl_latch[p] = 1'b0; end
        default: begin
          nx = m[NP-1:0];
          for (int q = 0; q < NP; q++)
            if ((nx[q] & ~cur[q] & mdl_mode[q][1]) | (~nx[q] & cur[q] & mdl_mode[q][0]))
              mdl_latch[q] = 1'b1;
          @(negedge clk_i) pins_i = nx;
          cur = nx;
          settle();
        end
      endcase
      rd(A_ST, d);
      chk("R9 random status", d, exp_status());
      chk("R11 random irq", {31'b0, irq_o}, {31'b0, exp_status() != 0});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule